// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer that software services through a small register port. A down-counter is loaded from a programmable period register and steps down once per watchdog tick. The tick comes from a prescaler that divides the system clock by a parameterised number of cycles. When the count runs out, the block raises a first-timeout status flag. It then reloads itself and keeps counting.

If the count runs out a second time with no reload in between, the block raises two flags: a second-timeout flag and a boot-failure flag. It also emits a one-cycle reset request, unless the external no-reboot input holds it back.

The register port has these properties:
- Registers are 16 bits wide and are word-selected by a 4-bit index.
- Writes take effect on the clock edge where `reg_we` is sampled high.
- Reads are combinational from `reg_addr`.
- The status words are write-1-to-clear.
- The control word carries a run/halt bit and a lock bit. Once set, the lock bit can only be cleared by reset.
- Writing either of the two data-port bytes raises a status flag as a side effect.

Top module: `wdt_top`

Register index map:

| Index | Register | Access |
|---|---|---|
| 0 | count | write reloads, read returns count |
| 1 | period | 10-bit |
| 2 | status A | bit0 expired, bit1 data-in event, bit2 data-out event |
| 3 | status B | bit0 second timeout, bit1 boot failure |
| 4 | control A | bit0 halt, bit1 lock |
| 5 | control B | 16-bit general |
| 6 | data-in | byte |
| 7 | data-out | byte |
| 8 | message A | byte |
| 9 | message B | byte |
| 10 | software interrupt | byte |

Byte registers keep `wdata[7:0]` and read back zero-extended.

## Requirements
- R1: After reset, these registers read as follows: count 0, period 4, both status words 0, control A 0, control B 0x0008, software-interrupt byte 0x03, and data and message bytes 0.
- R2: A write of any data to index 0 loads the counter from the period register, and reading index 0 returns the current count zero-extended to 16 bits.
- R3: While control A bit0 (halt) is 0, the count drops by one per tick. While it is 1, the count holds, and the prescaler phase is kept, so the first tick after release comes where it would have come.
- R4: After a load of N, the count reads 1 with status A bit0 still 0 just before the N-th tick. On the N-th tick, status A bit0 becomes 1 and the counter reloads to the period.
- R5: A second expiry with no reload since the first sets status B bit0 and bit1, and sets status A bit0 again. This happens even if software cleared status A bit0 in between.
- R6: On a second expiry, `rst_req` asserts only when `no_reboot` is 0. When `no_reboot` is 1, only the status bits change.
- R7: `rst_req` is high for exactly one cycle, and a reload write clears the record of an earlier expiry, so the next expiry counts as a first one.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged, so writing back a value just read returns the register to zero.
- R9: A write to index 6 sets status A bit1, a write to index 7 sets status A bit2, and both bytes store the written low byte.
- R10: Control A bit1 (lock) is sticky: after a 1 is written to it, later writes of 0 leave it at 1 until reset.
- R11: The period register is 10 bits wide, so writing 0xFFFF stores 0x3FF, and a load then gives a 1023-tick interval.
- R12: A count of 0 is idle: it neither decrements nor expires, so the block raises no timeout after reset until software loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| no_reboot | input | 1 | When 1, holds back the reset request on a second expiry |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with a tick of four clock cycles and the default 10-bit period. A tick of four cycles makes every tick boundary land at a known cycle after a reload. This brings the count-of-one cycle before expiry, the phase kept across a halt, and the exact cycle of the reset pulse within a few dozen cycles. With the same short tick, the full 1023-tick maximum interval fits in about four thousand cycles, so the masking of a 0xFFFF period is checked end to end rather than only at the register.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int REG_AW = 4;
  localparam int DATA_W = 16;

  typedef enum logic [REG_AW-1:0] {
    RA_COUNT  = 4'd0,
    RA_PERIOD = 4'd1,
    RA_STATA  = 4'd2,
    RA_STATB  = 4'd3,
    RA_CTRLA  = 4'd4,
    RA_CTRLB  = 4'd5,
    RA_DIN    = 4'd6,
    RA_DOUT   = 4'd7,
    RA_MSGA   = 4'd8,
    RA_MSGB   = 4'd9,
    RA_SWIRQ  = 4'd10
  } reg_idx_e;

  // status A bit positions
  localparam int SA_EXPIRED = 0;
  localparam int SA_DIN_EV  = 1;
  localparam int SA_DOUT_EV = 2;
  localparam int SA_W       = 3;

  // status B bit positions
  localparam int SB_SECOND = 0;
  localparam int SB_BOOT   = 1;
  localparam int SB_W      = 2;

  // control A bit positions
  localparam int CA_HALT = 0;
  localparam int CA_LOCK = 1;
  localparam int CA_W    = 2;

  localparam logic [DATA_W-1:0] CTRLB_RST  = 16'h0008;
  localparam logic [7:0]        SWIRQ_RST  = 8'h03;
  localparam int                PERIOD_RST = 4;

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int TICK_CYCLES = 60_000_000,
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);

  logic [PW-1:0] pre_q, pre_d;
  logic          last;

  assign last = (pre_q == PW'(TICK_CYCLES - 1));
  assign tick = run & last;

  always_comb begin
    pre_d = pre_q;
    if (restart)
      pre_d = '0;
    else if (run)
      pre_d = last ? '0 : pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pre_q <= '0;
    else
      pre_q <= pre_d;
  end

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             first_hit,
  output logic             second_hit
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             expire;

  assign expire     = tick & ~load & (cnt_q == CNT_W'(1));
  assign first_hit  = expire & ~armed_q;
  assign second_hit = expire & armed_q;
  assign count      = cnt_q;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (load) begin
      cnt_d   = period;
      armed_d = 1'b0;
    end else if (expire) begin
      cnt_d   = period;
      armed_d = 1'b1;
    end else if (tick && cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              first_hit,
  input  logic              second_hit,
  output logic [CNT_W-1:0]  period,
  output logic              halt,
  output logic              load
);

  logic [CNT_W-1:0]  per_q;
  logic [SA_W-1:0]   sa_q, sa_d;
  logic [SB_W-1:0]   sb_q, sb_d;
  logic [CA_W-1:0]   ca_q, ca_d;
  logic [DATA_W-1:0] cb_q;
  logic [7:0]        din_q, dout_q, msga_q, msgb_q, swirq_q;

  logic wr_per, wr_sa, wr_sb, wr_ca, wr_cb;
  logic wr_din, wr_dout, wr_msga, wr_msgb, wr_swirq;

  assign load     = reg_we & (reg_addr == RA_COUNT);
  assign wr_per   = reg_we & (reg_addr == RA_PERIOD);
  assign wr_sa    = reg_we & (reg_addr == RA_STATA);
  assign wr_sb    = reg_we & (reg_addr == RA_STATB);
  assign wr_ca    = reg_we & (reg_addr == RA_CTRLA);
  assign wr_cb    = reg_we & (reg_addr == RA_CTRLB);
  assign wr_din   = reg_we & (reg_addr == RA_DIN);
  assign wr_dout  = reg_we & (reg_addr == RA_DOUT);
  assign wr_msga  = reg_we & (reg_addr == RA_MSGA);
  assign wr_msgb  = reg_we & (reg_addr == RA_MSGB);
  assign wr_swirq = reg_we & (reg_addr == RA_SWIRQ);

  assign period = per_q;
  assign halt   = ca_q[CA_HALT];

  // status A: clear-by-one, event sets win over a clear in the same cycle
  always_comb begin
    sa_d = sa_q;
    if (wr_sa)
      sa_d = sa_q & ~reg_wdata[SA_W-1:0];
    if (first_hit || second_hit)
      sa_d[SA_EXPIRED] = 1'b1;
    if (wr_din)
      sa_d[SA_DIN_EV] = 1'b1;
    if (wr_dout)
      sa_d[SA_DOUT_EV] = 1'b1;
  end

  always_comb begin
    sb_d = sb_q;
    if (wr_sb)
      sb_d = sb_q & ~reg_wdata[SB_W-1:0];
    if (second_hit) begin
      sb_d[SB_SECOND] = 1'b1;
      sb_d[SB_BOOT]   = 1'b1;
    end
  end

  always_comb begin
    ca_d = ca_q;
    if (wr_ca) begin
      ca_d[CA_HALT] = reg_wdata[CA_HALT];
      ca_d[CA_LOCK] = ca_q[CA_LOCK] | reg_wdata[CA_LOCK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q <= '0;
      sb_q <= '0;
      ca_q <= '0;
    end else begin
      sa_q <= sa_d;
      sb_q <= sb_d;
      ca_q <= ca_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q   <= CNT_W'(PERIOD_RST);
      cb_q    <= CTRLB_RST;
      din_q   <= '0;
      dout_q  <= '0;
      msga_q  <= '0;
      msgb_q  <= '0;
      swirq_q <= SWIRQ_RST;
    end else begin
      if (wr_per)   per_q   <= reg_wdata[CNT_W-1:0];
      if (wr_cb)    cb_q    <= reg_wdata;
      if (wr_din)   din_q   <= reg_wdata[7:0];
      if (wr_dout)  dout_q  <= reg_wdata[7:0];
      if (wr_msga)  msga_q  <= reg_wdata[7:0];
      if (wr_msgb)  msgb_q  <= reg_wdata[7:0];
      if (wr_swirq) swirq_q <= reg_wdata[7:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_COUNT:  reg_rdata = DATA_W'(count);
      RA_PERIOD: reg_rdata = DATA_W'(per_q);
      RA_STATA:  reg_rdata = DATA_W'(sa_q);
      RA_STATB:  reg_rdata = DATA_W'(sb_q);
      RA_CTRLA:  reg_rdata = DATA_W'(ca_q);
      RA_CTRLB:  reg_rdata = cb_q;
      RA_DIN:    reg_rdata = DATA_W'(din_q);
      RA_DOUT:   reg_rdata = DATA_W'(dout_q);
      RA_MSGA:   reg_rdata = DATA_W'(msga_q);
      RA_MSGB:   reg_rdata = DATA_W'(msgb_q);
      RA_SWIRQ:  reg_rdata = DATA_W'(swirq_q);
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
  parameter int TICK_CYCLES = 60_000_000,
  parameter int CNT_W       = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        no_reboot,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        rst_req
);

  logic             tick;
  logic             load;
  logic             halt;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] cnt;
  logic             first_hit;
  logic             second_hit;
  logic             rst_d, rst_q;

  wdt_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load),
    .run     (~halt),
    .tick    (tick)
  );

  wdt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .load       (load),
    .period     (period),
    .count      (cnt),
    .first_hit  (first_hit),
    .second_hit (second_hit)
  );

  wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .count      (cnt),
    .first_hit  (first_hit),
    .second_hit (second_hit),
    .period     (period),
    .halt       (halt),
    .load       (load)
  );

  assign rst_d = second_hit & ~no_reboot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_q <= 1'b0;
    else
      rst_q <= rst_d;
  end

  assign rst_req = rst_q;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt,
  input logic             load,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] cnt,
  input logic             second_hit,
  input logic             no_reboot,
  input logic             rst_req,
  input logic [3:0]       reg_addr,
  input logic [15:0]      reg_rdata
);

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R7

  AST_RST_HELD_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (second_hit && no_reboot) |=> !rst_req); // R6

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !load) |=> $stable(cnt)); // R3

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(period))); // R2

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> (cnt == '0)); // R12

  AST_COUNT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 4'd0) |-> (reg_rdata == 16'(cnt))); // R2

endmodule

bind wdt_top wdt_checker #(.CNT_W(CNT_W)) u_wdt_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .halt       (halt),
  .load       (load),
  .period     (period),
  .cnt        (cnt),
  .second_hit (second_hit),
  .no_reboot  (no_reboot),
  .rst_req    (rst_req),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata)
);

// File: tb/test_wdt_top.sv
module test_wdt_top;
  import wdt_pkg::*;

  localparam int TICK = 4;
  localparam int N    = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        no_reboot;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        rst_req;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  wdt_top #(.TICK_CYCLES(TICK), .CNT_W(10)) i_wdt_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .no_reboot (no_reboot),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .rst_req   (rst_req)
  );

  typedef struct packed {
    logic        we;
    logic [3:0]  a;
    logic [15:0] d;
    logic [15:0] e;
  } vec_t;

  // register-port table (R1 defaults, R8 clear, R9 data ports, R10 lock, R11 mask)
  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd0,  16'h0000, 16'h0000},
    '{1'b0, 4'd1,  16'h0000, 16'h0004},
    '{1'b0, 4'd2,  16'h0000, 16'h0000},
    '{1'b0, 4'd3,  16'h0000, 16'h0000},
    '{1'b0, 4'd4,  16'h0000, 16'h0000},
    '{1'b0, 4'd5,  16'h0000, 16'h0008},
    '{1'b0, 4'd6,  16'h0000, 16'h0000},
    '{1'b0, 4'd7,  16'h0000, 16'h0000},
    '{1'b0, 4'd8,  16'h0000, 16'h0000},
    '{1'b0, 4'd9,  16'h0000, 16'h0000},
    '{1'b0, 4'd10, 16'h0000, 16'h0003},
    '{1'b1, 4'd8,  16'h125A, 16'h0000},
    '{1'b0, 4'd8,  16'h0000, 16'h005A},
    '{1'b1, 4'd9,  16'h00A5, 16'h0000},
    '{1'b0, 4'd9,  16'h0000, 16'h00A5},
    '{1'b1, 4'd5,  16'h1234, 16'h0000},
    '{1'b0, 4'd5,  16'h0000, 16'h1234},
    '{1'b1, 4'd1,  16'hFFFF, 16'h0000},
    '{1'b0, 4'd1,  16'h0000, 16'h03FF},
    '{1'b1, 4'd6,  16'h0077, 16'h0000},
    '{1'b0, 4'd2,  16'h0000, 16'h0002},
    '{1'b0, 4'd6,  16'h0000, 16'h0077},
    '{1'b1, 4'd7,  16'h0000, 16'h0000},
    '{1'b0, 4'd2,  16'h0000, 16'h0006},
    '{1'b1, 4'd2,  16'h0004, 16'h0000},
    '{1'b0, 4'd2,  16'h0000, 16'h0002},
    '{1'b1, 4'd2,  16'h0002, 16'h0000},
    '{1'b0, 4'd2,  16'h0000, 16'h0000},
    '{1'b1, 4'd4,  16'h0002, 16'h0000},
    '{1'b1, 4'd4,  16'h0000, 16'h0000},
    '{1'b0, 4'd4,  16'h0000, 16'h0002}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rchk(input string tag, input logic [3:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic clear_status();
    wr(RA_STATA, 16'h0007);
    wr(RA_STATB, 16'h0003);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired got=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seen;
    rst_n     = 1'b0;
    no_reboot = 1'b0;
    reg_we    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    step(3);
    rst_n = 1'b1;

    // R12: idle zero count raises nothing
    step(40);
    rchk("R12 status A after idle", RA_STATA, 16'h0000);
    rchk("R12 count stays zero", RA_COUNT, 16'h0000);
    chk("R1 rst_req low after reset", 16'(rst_req), 16'h0000);

    // table walk: R1 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we)
        wr(VEC[i].a, VEC[i].d);
      else
        rchk($sformatf("R1/R8/R9/R10/R11 table[%0d]", i), VEC[i].a, VEC[i].e);
    end

    // R2 R4 R5 R6 R7 R8: first and second expiry
    clear_status();
    wr(RA_PERIOD, 16'd5);
    wr(RA_COUNT, 16'h0000);                       // k = 0
    rchk("R2 count after load", RA_COUNT, 16'd5);
    step(TICK*N - 1);                             // k = 19
    rchk("R4 count one before expiry", RA_COUNT, 16'd1);
    rchk("R4 no timeout yet", RA_STATA, 16'h0000);
    step(1);                                      // k = 20
    rchk("R4 first timeout flag", RA_STATA, 16'h0001);
    rchk("R4 self reload", RA_COUNT, 16'd5);
    chk("R6 no reset on first", 16'(rst_req), 16'h0000);
    wr(RA_STATA, 16'h0001);                       // k = 21
    rchk("R8 expired flag cleared", RA_STATA, 16'h0000);
    step(2*TICK*N - 22);                          // k = 39
    rchk("R5 no second yet", RA_STATB, 16'h0000);
    step(1);                                      // k = 40
    chk("R6 reset request", 16'(rst_req), 16'h0001);
    rchk("R5 second and boot flags", RA_STATB, 16'h0003);
    rchk("R5 expired set again", RA_STATA, 16'h0001);
    step(1);
    chk("R7 reset pulse one cycle", 16'(rst_req), 16'h0000);
    wr(RA_STATB, 16'h0003);
    rchk("R8 status B cleared", RA_STATB, 16'h0000);

    // R7: reload between expiries restarts the escalation
    clear_status();
    wr(RA_COUNT, 16'h0000);
    step(TICK*N);
    rchk("R7 first expiry", RA_STATA, 16'h0001);
    wr(RA_COUNT, 16'h0000);
    seen = 0;
    for (int i = 0; i < TICK*N; i++) begin
      step(1);
      if (rst_req) seen = 1;
    end
    rchk("R7 reload clears expiry record", RA_STATB, 16'h0000);
    chk("R7 no reset after reload", 16'(seen), 16'h0000);

    // R6: no_reboot holds back the request
    clear_status();
    no_reboot = 1'b1;
    wr(RA_COUNT, 16'h0000);
    seen = 0;
    for (int i = 0; i < 2*TICK*N + 2; i++) begin
      step(1);
      if (rst_req) seen = 1;
    end
    chk("R6 held back by no_reboot", 16'(seen), 16'h0000);
    rchk("R6 status still updated", RA_STATB, 16'h0003);
    no_reboot = 1'b0;

    // R3 R10: halt freezes, phase kept, lock sticky
    clear_status();
    wr(RA_COUNT, 16'h0000);                       // k = 0
    step(6);                                      // k = 6
    rchk("R3 count decremented", RA_COUNT, 16'd4);
    wr(RA_CTRLA, 16'h0001);                       // k = 7
    step(20);
    rchk("R3 count frozen", RA_COUNT, 16'd4);
    rchk("R10 lock kept with halt", RA_CTRLA, 16'h0003);
    wr(RA_CTRLA, 16'h0000);
    rchk("R3 still frozen at release", RA_COUNT, 16'd4);
    step(1);
    rchk("R3 phase kept across halt", RA_COUNT, 16'd3);
    rchk("R10 lock after write of 0", RA_CTRLA, 16'h0002);

    // R11: max period 1023 ticks
    wr(RA_PERIOD, 16'hFFFF);
    wr(RA_COUNT, 16'h0000);                       // k = 0
    rchk("R11 loaded masked period", RA_COUNT, 16'h03FF);
    clear_status();                               // k = 2
    step(TICK*1023 - 3);
    rchk("R11 count one before max expiry", RA_COUNT, 16'd1);
    rchk("R11 no timeout yet", RA_STATA, 16'h0000);
    step(1);
    rchk("R11 max timeout flag", RA_STATA, 16'h0001);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule